// File: doc/BRIEF.md
# Colour-Matrix Coefficient Encoder and Register Packer

This block turns colour-conversion matrix coefficients from a wide signed-magnitude fixed-point form into the compact 16-bit pseudo-float word that a pipe colour-space converter consumes. Each input coefficient is 64 bits wide. Bit 63 is the sign. Bits 62:0 are an unsigned magnitude with 32 fractional bits. The encoder first saturates the magnitude to just below 4.0. It then picks one of six ranges from the size of the magnitude, which slides a 9-bit mantissa window over the most significant bits. Finally it rounds the mantissa and packs the sign, a 3-bit range code and the mantissa into one word.

Coefficients arrive one per clock on a valid/ready stream, row by row, three per matrix row. A packer groups them into 32-bit register words. The first two coefficients of a row share one word. The third coefficient sits alone in the upper half of a second word. Both the coefficient stage and the packed output are registered, and back-pressure from the consumer propagates to the input.

Top module: `csc_coef_encoder`

## Requirements
- R1: Input bit 63 is copied unchanged into bit 15 of the encoded coefficient. This holds for zero magnitudes too, so a negative zero encodes as 16'hB000.
- R2: Magnitudes at or above 4.0 (bits 62:0 greater than 34'h3_FFFF_FFFF) are treated as 4.0 minus one LSB. For example, 100.0 encodes as 16'h6FF8 and -8.0 as 16'hEFF8.
- R3: The range code in bits 14:12, and the fraction bits kept, follow the magnitude m: m<0.125 gives code 3 with 12 bits, m<0.25 gives code 2 with 11, m<0.5 gives code 1 with 10, m<1.0 gives code 0 with 9, m<2.0 gives code 7 with 8, and any larger m gives code 6 with 7. Codes 4 and 5 never appear.
- R4: The 12-bit field is the magnitude shifted right by (29 - fraction bits) plus 4, clamped at 12'hFFF. Its upper 9 bits form the mantissa in bits 11:3. A value just below a range boundary therefore yields mantissa 9'h1FF and does not wrap.
- R5: Bits 2:0 of every coefficient are zero.
- R6: For each row, the first output word carries coefficient one in bits 31:16 and coefficient two in bits 15:0, with out_single low.
- R7: The second output word of each row carries coefficient three in bits 31:16 and zero in bits 15:0, with out_single high.
- R8: A magnitude of exactly 1.0 encodes as 16'h7800, and a zero magnitude encodes as 16'h3000.
- R9: When out_ready stays high, one coefficient is accepted every clock. When out_valid is high and out_ready is low, the output word and flag hold stable until the word is taken.
- R10: Reset clears out_valid, raises in_ready, and discards a partly collected row, so that the next coefficient accepted is the first of a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input coefficient is present |
| in_ready | output | 1 | Block can accept a coefficient |
| in_coeff | input | 64 | Sign bit 63, magnitude 62:0 with 32 fraction bits |
| out_valid | output | 1 | A packed register word is present |
| out_ready | input | 1 | Consumer takes the packed word |
| out_word | output | 32 | Packed register word |
| out_single | output | 1 | Word holds only a row's third coefficient |

## Verification
Hand-picked rows place magnitudes exactly on each range boundary and one LSB below it. These separate a wrong comparison direction from a missing mantissa clamp. Rows with negative values, negative zero and oversized values isolate the sign path from saturation. Rounding rows differ only in the three guard bits, which exposes a missing or misplaced rounding increment. Pseudo-random rows are driven under a toggling consumer-ready pattern and compared against an independent model, which checks both the packing order and the hold behaviour under back-pressure. A reset in the middle of a row shows that the packer restarts at the first slot.

// File: rtl/csc_enc_pkg.sv
package csc_enc_pkg;

    localparam int IN_W      = 64;
    localparam int FRAC_W    = 32;
    localparam int SAT_INT_W = 2;
    localparam int MAG_W     = FRAC_W + SAT_INT_W;
    localparam int MANT_W    = 9;
    localparam int GUARD_W   = 3;
    localparam int FIELD_W   = MANT_W + GUARD_W;
    localparam int RC_W      = 3;
    localparam int COEF_W    = 1 + RC_W + MANT_W + GUARD_W;
    localparam int REG_W     = 2 * COEF_W;
    localparam int NUM_BOUND = 5;
    localparam int LOW_EXP   = 3;
    localparam int FB_MAX    = FRAC_W - GUARD_W - (FRAC_W - FIELD_W) + LOW_EXP - GUARD_W;
    localparam int IDX_W     = $clog2(NUM_BOUND + 1);

    typedef logic [MAG_W-1:0] mag_t;

    typedef struct packed {
        logic              sign;
        logic [RC_W-1:0]   rcode;
        logic [MANT_W-1:0] mant;
        logic [GUARD_W-1:0] pad;
    } coef_t;

    typedef struct packed {
        logic [RC_W-1:0] rcode;
        logic [3:0]      fbits;
    } range_t;

    typedef enum logic [1:0] {
        SLOT_FIRST  = 2'd0,
        SLOT_SECOND = 2'd1,
        SLOT_THIRD  = 2'd2
    } slot_e;

    localparam mag_t MAG_MAX = {MAG_W{1'b1}};

    function automatic mag_t sat_mag(input logic [IN_W-2:0] raw);
        if (raw > (IN_W-1)'(MAG_MAX)) return MAG_MAX;
        return raw[MAG_W-1:0];
    endfunction

    function automatic logic [RC_W-1:0] code_of(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 3'd3;
            3'd1:    return 3'd2;
            3'd2:    return 3'd1;
            3'd3:    return 3'd0;
            3'd4:    return 3'd7;
            default: return 3'd6;
        endcase
    endfunction

    function automatic logic [MANT_W-1:0] round_window(input mag_t m, input logic [3:0] fbits);
        int               sh;
        mag_t             part;
        logic [MAG_W:0]   sum;
        sh   = FRAC_W - GUARD_W - int'(fbits);
        part = m >> sh;
        sum  = {1'b0, part} + (MAG_W+1)'(1 << (GUARD_W - 1));
        if (sum > (MAG_W+1)'((1 << FIELD_W) - 1))
            sum = (MAG_W+1)'((1 << FIELD_W) - 1);
        return sum[FIELD_W-1:GUARD_W];
    endfunction

endpackage

// File: rtl/csc_range_sel.sv
module csc_range_sel
    import csc_enc_pkg::*;
(
    input  mag_t   mag,
    output range_t rng
);
    logic [NUM_BOUND-1:0] above;
    logic [IDX_W-1:0]     idx;

    for (genvar k = 0; k < NUM_BOUND; k++) begin : g_bound
        assign above[k] = (mag >= (mag_t'(1) << (FRAC_W - LOW_EXP + k)));
    end

    always_comb begin
        idx = '0;
        for (int k = 0; k < NUM_BOUND; k++)
            idx = idx + IDX_W'(above[k]);
    end

    assign rng.rcode = code_of(idx);
    assign rng.fbits = 4'(FIELD_W) - 4'(idx);
endmodule

// File: rtl/csc_enc_stage.sv
module csc_enc_stage
    import csc_enc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [IN_W-1:0] in_coeff,
    output logic            dn_valid,
    input  logic            dn_ready,
    output coef_t           dn_word
);
    mag_t   mag_s;
    range_t rng;
    coef_t  enc_d;

    assign mag_s = sat_mag(in_coeff[IN_W-2:0]);

    csc_range_sel u_rsel (
        .mag (mag_s),
        .rng (rng)
    );

    always_comb begin
        enc_d.sign  = in_coeff[IN_W-1];
        enc_d.rcode = rng.rcode;
        enc_d.mant  = round_window(mag_s, rng.fbits);
        enc_d.pad   = '0;
    end

    assign in_ready = !dn_valid || dn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_valid <= 1'b0;
            dn_word  <= '0;
        end else if (in_ready) begin
            dn_valid <= in_valid;
            if (in_valid) dn_word <= enc_d;
        end
    end

    // R1
    sign_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (dn_word.sign == $past(in_coeff[IN_W-1])));

    // R3
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> (dn_word.rcode != 3'd4 && dn_word.rcode != 3'd5));

    // R9
    enc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_word)));
endmodule

// File: rtl/csc_row_packer.sv
module csc_row_packer
    import csc_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             up_valid,
    output logic             up_ready,
    input  coef_t            up_word,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [REG_W-1:0] out_word,
    output logic             out_single
);
    slot_e slot_q;
    coef_t hold_q;
    logic  take;

    assign up_ready = (slot_q == SLOT_FIRST) || !out_valid || out_ready;
    assign take     = up_valid && up_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q     <= SLOT_FIRST;
            hold_q     <= '0;
            out_valid  <= 1'b0;
            out_word   <= '0;
            out_single <= 1'b0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (take) begin
                case (slot_q)
                    SLOT_FIRST: begin
                        hold_q <= up_word;
                        slot_q <= SLOT_SECOND;
                    end
                    SLOT_SECOND: begin
                        out_word   <= {hold_q, up_word};
                        out_single <= 1'b0;
                        out_valid  <= 1'b1;
                        slot_q     <= SLOT_THIRD;
                    end
                    default: begin
                        out_word   <= {up_word, {COEF_W{1'b0}}};
                        out_single <= 1'b1;
                        out_valid  <= 1'b1;
                        slot_q     <= SLOT_FIRST;
                    end
                endcase
            end
        end
    end

    // R5
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word[2:0] == 3'd0 && out_word[COEF_W+2:COEF_W] == 3'd0));

    // R7
    single_low_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_single) |-> (out_word[COEF_W-1:0] == '0));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_single)));
endmodule

// File: rtl/csc_coef_encoder.sv
module csc_coef_encoder
    import csc_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_coeff,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [REG_W-1:0] out_word,
    output logic             out_single
);
    logic  enc_valid;
    logic  enc_ready;
    coef_t enc_word;

    csc_enc_stage u_enc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_coeff (in_coeff),
        .dn_valid (enc_valid),
        .dn_ready (enc_ready),
        .dn_word  (enc_word)
    );

    csc_row_packer u_pack (
        .clk        (clk),
        .rst        (rst),
        .up_valid   (enc_valid),
        .up_ready   (enc_ready),
        .up_word    (enc_word),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_word   (out_word),
        .out_single (out_single)
    );
endmodule

// File: tb/test_csc_coef_encoder.sv
module test_csc_coef_encoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_coeff = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;
    logic        out_single;

    always #5 clk = ~clk;

    csc_coef_encoder i_csc_coef_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_coeff(in_coeff), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .out_single(out_single)
    );

    typedef struct { logic [31:0] w; logic s; string tag; } exp_t;
    exp_t q[$];

    int tests = 0, fails = 0, stalls = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic held = 1'b0;
    logic [31:0] held_w;
    logic held_s;
    logic done = 1'b0;

    localparam logic [63:0] ONE = 64'h1_0000_0000;

    function automatic logic [63:0] neg(input logic [63:0] c);
        return {1'b1, c[62:0]};
    endfunction

    function automatic logic [15:0] model(input logic [63:0] c);
        logic [62:0] m;
        logic [62:0] f;
        int fb;
        logic [2:0] rc;
        m = c[62:0];
        if (m > 63'h3_FFFF_FFFF) m = 63'h3_FFFF_FFFF;
        if      (m < 63'h0_2000_0000) begin rc = 3'd3; fb = 12; end
        else if (m < 63'h0_4000_0000) begin rc = 3'd2; fb = 11; end
        else if (m < 63'h0_8000_0000) begin rc = 3'd1; fb = 10; end
        else if (m < 63'h1_0000_0000) begin rc = 3'd0; fb = 9;  end
        else if (m < 63'h2_0000_0000) begin rc = 3'd7; fb = 8;  end
        else                          begin rc = 3'd6; fb = 7;  end
        f = (m >> (29 - fb)) + 63'd4;
        if (f > 63'hFFF) f = 63'hFFF;
        return {c[63], rc, f[11:3], 3'b000};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_coef(input logic [63:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_coeff = c;
        #2;
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
            #2;
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic send_row(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                            input logic [15:0] ea, input logic [15:0] eb, input logic [15:0] ec,
                            input string tag);
        exp_t e;
        e.w = {ea, eb}; e.s = 1'b0; e.tag = {tag, " R6"}; q.push_back(e);
        e.w = {ec, 16'h0}; e.s = 1'b1; e.tag = {tag, " R7"}; q.push_back(e);
        send_coef(a);
        send_coef(b);
        send_coef(c);
    endtask

    task automatic send_model_row(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
        send_row(a, b, c, model(a), model(b), model(c), "R3 R4 model");
    endtask

    task automatic drain;
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
        #1;
        if (!rst) begin
            if (held) begin
                check(out_valid && out_word == held_w && out_single == held_s,
                      "R9 hold", {31'd0, out_valid, out_word}, {31'd1, held_w});
            end
            held = 1'b0;
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    check(1'b0, "R6 unexpected word", {32'd0, out_word}, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_word == e.w && out_single == e.s, e.tag,
                          {31'd0, out_single, out_word}, {31'd0, e.s, e.w});
                end
            end else if (out_valid) begin
                held = 1'b1; held_w = out_word; held_s = out_single;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        check(!out_valid && in_ready, "R10 reset", {62'd0, out_valid, in_ready}, 64'd1);

        // R8 identity and zero
        send_row(ONE, 64'd0, 64'd0, 16'h7800, 16'h3000, 16'h3000, "R8 identity");
        // R1 signs, negative zero
        send_row(neg(ONE), neg(64'd0), neg(64'h8000_0000), 16'hF800, 16'hB000, 16'h8800, "R1 sign");
        // R2 saturation
        send_row(64'h64_0000_0000, neg(64'h8_0000_0000), 64'h3_FFFF_FFFF, 16'h6FF8, 16'hEFF8, 16'h6FF8, "R2 sat");
        // R3 boundaries
        send_row(64'h2000_0000, 64'h1FFF_FFFF, 64'h4000_0000, 16'h2800, 16'h3FF8, 16'h1800, "R3 R4 bound");
        send_row(64'h8000_0000, 64'h7FFF_FFFF, 64'h1_FFFF_FFFF, 16'h0800, 16'h1FF8, 16'h7FF8, "R3 R4 bound2");
        send_row(64'h2_0000_0000, 64'h8040_0000, 64'h803F_FFFF, 16'h6800, 16'h0808, 16'h0800, "R3 R4 round");
        send_row(64'h2_0000, 64'h8_0000, neg(64'h3_FFFF_FFFF), 16'h3000, 16'h3008, 16'hEFF8, "R4 R5 small");
        drain();

        // R9 full throughput
        stalls = 0;
        for (int i = 0; i < 6; i++)
            send_model_row({lfsr[0], 7'd0, lfsr, lfsr ^ 16'h5A5A, lfsr, 8'd0},
                           {lfsr[1], 29'd0, lfsr[2:0], lfsr, 16'h0},
                           {lfsr[3], 31'd0, lfsr, 16'h1234});
        check(stalls == 0, "R9 throughput", 64'(stalls), 64'd0);
        drain();

        // R9 back-pressure with random rows
        rdy_mode = 1;
        for (int i = 0; i < 25; i++) begin
            logic [63:0] a, b, c;
            a = {lfsr[5], 27'd0, lfsr[3:0], lfsr, lfsr ^ 16'h3C3C};
            b = {lfsr[6], 29'd0, lfsr[1:0], lfsr[0], lfsr ^ 16'hF00F, lfsr};
            c = {lfsr[7], 30'd0, lfsr[2:0], 3'd0, lfsr[9:0], lfsr, 2'd0};
            send_model_row(a, b, c);
        end
        rdy_mode = 0;
        drain();

        // R10 reset mid-row
        send_coef(64'h1_8000_0000);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!out_valid && in_ready, "R10 reset mid-row", {62'd0, out_valid, in_ready}, 64'd1);
        send_row(64'd0, ONE, 64'd0, 16'h3000, 16'h7800, 16'h3000, "R10 restart");
        drain();
        check(q.size() == 0, "R6 queue empty", 64'(q.size()), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule